// File: doc/BRIEF.md
# Serial DAC Word Receiver and Update Controller

This block is the digital front end of a serial-input digital-to-analog converter. A host writes one 16-bit word per frame: the active-low frame input is held low while the data input is captured on every falling edge of the serial clock, most significant bit first. The data field of the word is moved into the converter code register. This happens either automatically when the frame closes or later, when the host pulses the load strobe. The choice between the two is made by sampling the load strobe when the frame opens.

The shift register can also be reloaded from the code register, so the host can read the stored code back on the serial output. Without that reload the serial output repeats the input stream 16 clocks late, so several converters can be chained. A clear input forces the converter output to its zero level without touching any register. A power-down input is passed through as a status flag. All pins are synchronised into a faster system clock, and every action happens in that clock domain, three system clocks after the pin edge.

Three state machines run the block:
- The frame machine (`FR_IDLE`, `FR_RECV`, `FR_FULL`):
  - `FR_IDLE` goes to `FR_RECV` when the frame opens.
  - `FR_RECV` goes to `FR_FULL` on the 16th clock fall.
  - `FR_RECV` goes back to `FR_IDLE` when the frame closes early, and the word is discarded.
  - `FR_FULL` goes to `FR_IDLE` when the frame closes, and the word is delivered.
- The load machine (`LD_IDLE`, `LD_PEND`):
  - `LD_IDLE` goes to `LD_PEND` when a word is delivered in deferred mode.
  - `LD_PEND` goes to `LD_IDLE` when the strobe goes low, and the code register is loaded.
  - `LD_PEND` goes to `LD_IDLE` when a new frame opens, and the pending update is dropped.
- The output machine (`OUT_LIVE`, `OUT_CLR`, `OUT_PARK`):
  - `OUT_LIVE` goes to `OUT_CLR` on a clear falling edge.
  - `OUT_CLR` goes to `OUT_LIVE` when clear is released with the strobe low.
  - `OUT_CLR` goes to `OUT_PARK` when clear is released with the strobe high.
  - `OUT_PARK` goes to `OUT_LIVE` when the strobe goes low.
  - `OUT_PARK` goes to `OUT_CLR` on a new clear falling edge.

Top module: `sdac_front`

## Requirements
- R1: After reset the code register is 0, the zero-output flag is 0 and the power-down flag is 0.
- R2: A frame of 16 clock falls delivers a word sent bit 15 first. With DATA_W=14 the code is bits 13..0 and bits 15..14 are ignored. With DATA_W=12 the code is bits 13..2.
- R3: If the strobe is low when the frame opens, the code register keeps its value during the frame and takes the new code when the frame closes.
- R4: If the strobe is high when the frame opens, closing the frame leaves the code register unchanged, and the new code is loaded when the strobe is next driven low.
- R5: Driving the strobe low when no deferred word is pending does not change the code register.
- R6: A frame that closes after fewer than 16 clock falls leaves the code register unchanged.
- R7: Outside readback, the serial output after each clock fall equals the bit captured 16 falls earlier, so a whole previous word leaves bit 15 first.
- R8: The first clock fall after the readback input falls loads the shift register with the code register, placed as in R2, with bits 15..14 and any unused low bits at 0. The following falls shift it out bit 15 first.
- R9: A clear falling edge sets the zero-output flag, and neither the code register nor the shift register (seen on the serial output) changes.
- R10: When clear is released with the strobe low the zero-output flag drops. With the strobe high it stays set until the strobe goes low.
- R11: The power-down flag follows the power-down input, and the code register is not altered by it.
- R12: The serial output is open drain: the drive enable is 1 exactly when the data bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data captured on its falling edge |
| frame_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low load strobe |
| rbk_n_i | input | 1 | Active-low readback request |
| clr_n_i | input | 1 | Active-low clear |
| pd_i | input | 1 | Power-down request |
| dac_code_o | output | DATA_W | Converter code register |
| out_zero_o | output | 1 | Output forced to zero level |
| pwrdn_o | output | 1 | Power-down status |
| sdo_o | output | 1 | Serial output data bit |
| sdo_oe_o | output | 1 | Open-drain pull-low enable |

## Verification
Automatic-update frames are driven with words whose top two bits are set, cleared and mixed. These tell a correct field slice apart from one that leaks the ignored bits or drops low bits. Deferred frames, a stray strobe with nothing pending and a truncated frame separate the three reasons a code may or may not be loaded. A chained second frame and a readback stream separate the delayed raw word from the padded code register, because the chosen word differs from its code in its top bits. Clear is released once with the strobe high and once with it low to separate parking from immediate return.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int WORD_W = 16;
    localparam int PAD_HI = 2;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RECV = 2'd1,
        FR_FULL = 2'd2
    } frame_st_e;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_PEND = 1'b1
    } load_st_e;

    typedef enum logic [1:0] {
        OUT_LIVE = 2'd0,
        OUT_CLR  = 2'd1,
        OUT_PARK = 2'd2
    } out_st_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int           N        = 7,
    parameter int           STAGES   = 2,
    parameter logic [N-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], raw_i[b]};
        end
        assign lvl_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall_i,
    input  logic              frame_lvl_i,
    input  logic              frame_fall_i,
    input  logic              frame_rise_i,
    input  logic              sdin_i,
    input  logic              ldac_lvl_i,
    input  logic              rbk_lvl_i,
    input  logic              rbk_fall_i,
    input  logic [DATA_W-1:0] dac_i,
    output logic [DATA_W-1:0] code_o,
    output logic              sdo_o,
    output logic              word_done_o,
    output logic              auto_o
);
    localparam int LSB_POS = WORD_W - PAD_HI - DATA_W;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    frame_st_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] rb_word;
    logic              arm_q;
    logic              auto_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE: if (frame_fall_i) st_d = FR_RECV;
            FR_RECV: begin
                if (frame_rise_i)                          st_d = FR_IDLE;
                else if (sclk_fall_i && cnt_q == LAST)     st_d = FR_FULL;
            end
            FR_FULL: if (frame_rise_i) st_d = FR_IDLE;
            default: st_d = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_done_o = (st_q == FR_FULL) && frame_rise_i;
        auto_o      = auto_q;
        sdo_o       = sr_q[WORD_W-1];
        code_o      = sr_q[LSB_POS +: DATA_W];
    end

    always_comb begin
        rb_word                    = '0;
        rb_word[LSB_POS +: DATA_W] = dac_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            auto_q <= 1'b0;
            arm_q  <= 1'b0;
            sr_q   <= '0;
        end else begin
            if (frame_fall_i) begin
                cnt_q  <= '0;
                auto_q <= ~ldac_lvl_i;
            end else if (st_q == FR_RECV && sclk_fall_i) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (rbk_fall_i)       arm_q <= 1'b1;
            else if (sclk_fall_i) arm_q <= 1'b0;

            if (sclk_fall_i) begin
                if (arm_q)
                    sr_q <= rb_word;
                else if (!frame_lvl_i || !rbk_lvl_i)
                    sr_q <= {sr_q[WORD_W-2:0], sdin_i};
            end
        end
    end

    // R7
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall_i && !arm_q && !frame_lvl_i) |=> (sr_q[0] == $past(sdin_i)));

    // R8
    rb_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall_i && arm_q) |=> (sr_q[WORD_W-1 -: PAD_HI] == '0));
endmodule

// File: rtl/sdac_update.sv
module sdac_update
    import sdac_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done_i,
    input  logic              auto_i,
    input  logic [DATA_W-1:0] code_i,
    input  logic              ldac_lvl_i,
    input  logic              frame_fall_i,
    input  logic              clr_lvl_i,
    input  logic              clr_fall_i,
    output logic [DATA_W-1:0] dac_o,
    output logic              out_zero_o
);
    load_st_e          ld_q, ld_d;
    out_st_e           out_q, out_d;
    logic [DATA_W-1:0] dac_q;
    logic              load_now;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q  <= LD_IDLE;
            out_q <= OUT_LIVE;
        end else begin
            ld_q  <= ld_d;
            out_q <= out_d;
        end
    end

    // load machine next state
    always_comb begin
        ld_d = ld_q;
        unique case (ld_q)
            LD_IDLE: if (word_done_i && !auto_i)           ld_d = LD_PEND;
            LD_PEND: if (frame_fall_i || !ldac_lvl_i)      ld_d = LD_IDLE;
            default: ld_d = LD_IDLE;
        endcase
    end

    // output machine next state
    always_comb begin
        out_d = out_q;
        unique case (out_q)
            OUT_LIVE: if (clr_fall_i) out_d = OUT_CLR;
            OUT_CLR:  if (clr_lvl_i)  out_d = ldac_lvl_i ? OUT_PARK : OUT_LIVE;
            OUT_PARK: begin
                if (clr_fall_i)       out_d = OUT_CLR;
                else if (!ldac_lvl_i) out_d = OUT_LIVE;
            end
            default: out_d = OUT_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        load_now   = (word_done_i && auto_i) ||
                     (ld_q == LD_PEND && !ldac_lvl_i && !frame_fall_i);
        out_zero_o = (out_q != OUT_LIVE);
        dac_o      = dac_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dac_q <= '0;
        else if (load_now) dac_q <= code_i;
    end

    // R3
    auto_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done_i && auto_i) |=> (dac_q == $past(code_i)));

    // R4
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done_i && !auto_i) |=> $stable(dac_q));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q == LD_IDLE && !word_done_i) |=> $stable(dac_q));

    // R9
    clr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall_i |=> out_zero_o);

    // R10
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q == OUT_PARK && ldac_lvl_i && !clr_fall_i) |=> out_zero_o);
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              frame_n_i,
    input  logic              sdin_i,
    input  logic              ldac_n_i,
    input  logic              rbk_n_i,
    input  logic              clr_n_i,
    input  logic              pd_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              out_zero_o,
    output logic              pwrdn_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam int N_IN    = 7;
    localparam int I_SCLK  = 0;
    localparam int I_FRAME = 1;
    localparam int I_SDIN  = 2;
    localparam int I_LDAC  = 3;
    localparam int I_RBK   = 4;
    localparam int I_CLR   = 5;
    localparam int I_PD    = 6;
    localparam logic [N_IN-1:0] IDLE_VAL = 7'b0111011;

    logic [N_IN-1:0]   raw, lvl;
    logic [3:0]        watch, dly_q, fall;
    logic              frame_rise;
    logic [DATA_W-1:0] code, dac;
    logic              word_done, auto_upd, sdo_bit;

    assign raw = {pd_i, clr_n_i, rbk_n_i, ldac_n_i, sdin_i, frame_n_i, sclk_i};

    sdac_sync #(
        .N(N_IN), .STAGES(SYNC_STAGES), .IDLE_VAL(IDLE_VAL)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .lvl_o(lvl)
    );

    assign watch = {lvl[I_CLR], lvl[I_RBK], lvl[I_FRAME], lvl[I_SCLK]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 4'b1111;
        else        dly_q <= watch;
    end

    assign fall       = dly_q & ~watch;
    assign frame_rise = ~dly_q[1] & watch[1];

    sdac_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_fall_i(fall[0]),
        .frame_lvl_i(lvl[I_FRAME]),
        .frame_fall_i(fall[1]),
        .frame_rise_i(frame_rise),
        .sdin_i(lvl[I_SDIN]),
        .ldac_lvl_i(lvl[I_LDAC]),
        .rbk_lvl_i(lvl[I_RBK]),
        .rbk_fall_i(fall[2]),
        .dac_i(dac),
        .code_o(code),
        .sdo_o(sdo_bit),
        .word_done_o(word_done),
        .auto_o(auto_upd)
    );

    sdac_update #(.DATA_W(DATA_W)) u_upd (
        .clk(clk), .rst_n(rst_n),
        .word_done_i(word_done),
        .auto_i(auto_upd),
        .code_i(code),
        .ldac_lvl_i(lvl[I_LDAC]),
        .frame_fall_i(fall[1]),
        .clr_lvl_i(lvl[I_CLR]),
        .clr_fall_i(fall[3]),
        .dac_o(dac),
        .out_zero_o(out_zero_o)
    );

    assign dac_code_o = dac;
    assign pwrdn_o    = lvl[I_PD];
    assign sdo_o      = sdo_bit;
    assign sdo_oe_o   = ~sdo_bit;

    // R11
    pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(lvl[I_PD]) && !word_done) |=> $stable(dac_code_o));
endmodule

// File: tb/sdac_front_test.sv
module sdac_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic sclk = 1'b1, frm_n = 1'b1, sdin = 1'b0, ld_n = 1'b1;
    logic rb_n = 1'b1, clr_n = 1'b1, pd = 1'b0;
    logic [13:0] code;
    logic zero, pdn, sdo, sdo_oe;

    int checks = 0;
    int fails  = 0;

    sdac_front uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frm_n),
        .sdin_i(sdin), .ldac_n_i(ld_n), .rbk_n_i(rb_n), .clr_n_i(clr_n),
        .pd_i(pd), .dac_code_o(code), .out_zero_o(zero), .pwrdn_o(pdn),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    // word in [31:16], expected code in [15:0]
    localparam logic [31:0] TBL [6] = '{
        32'hC000_0000, 32'h3FFF_3FFF, 32'hFFFF_3FFF,
        32'h2A55_2A55, 32'h9234_1234, 32'h4001_0001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic d);
        sdin = d;
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(5);
        sclk = 1'b1;
        wait_clk(4);
    endtask

    task automatic frame_open(input logic ld_low);
        ld_n = ~ld_low;
        wait_clk(4);
        frm_n = 1'b0;
        wait_clk(5);
    endtask

    task automatic shift_word(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) pulse_bit(w[15-i]);
    endtask

    task automatic frame_close();
        wait_clk(2);
        frm_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        logic        s0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 code", 32'(code), 32'h0);
        chk("R1 zero", 32'(zero), 32'h0);
        chk("R1 pdn", 32'(pdn), 32'h0);

        // R2: automatic-update vectors
        for (int i = 0; i < 6; i++) begin
            frame_open(1'b1);
            shift_word(TBL[i][31:16], 16);
            frame_close();
            chk("R2", 32'(code), 32'(TBL[i][15:0]));
        end

        // R3: no change before the frame closes
        frame_open(1'b1);
        shift_word(16'h1111, 16);
        chk("R3 before close", 32'(code), 32'h0001);
        frame_close();
        chk("R3 after close", 32'(code), 32'h1111);

        // R4: deferred update
        frame_open(1'b0);
        shift_word(16'h0ABC, 16);
        frame_close();
        chk("R4 held", 32'(code), 32'h1111);
        ld_n = 1'b0;
        wait_clk(6);
        chk("R4 strobe", 32'(code), 32'h0ABC);

        // R5: strobe with nothing pending
        ld_n = 1'b1;
        wait_clk(6);
        ld_n = 1'b0;
        wait_clk(6);
        chk("R5", 32'(code), 32'h0ABC);

        // R6: truncated frame
        frame_open(1'b1);
        shift_word(16'h3333, 10);
        frame_close();
        chk("R6", 32'(code), 32'h0ABC);

        // R7: chained output
        frame_open(1'b1);
        shift_word(16'hB5C3, 16);
        frame_close();
        chk("R2 top bits", 32'(code), 32'h35C3);
        frame_open(1'b1);
        for (int i = 0; i < 16; i++) begin
            got[15-i] = sdo;
            pulse_bit(16'hCF0F >> (15 - i));
        end
        frame_close();
        chk("R7", 32'(got), 32'hB5C3);
        chk("R7 code", 32'(code), 32'h0F0F);
        chk("R12 high", 32'({sdo, sdo_oe}), 32'h2);

        // R8: readback with frame high
        rb_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 16; i++) begin
            pulse_bit(1'b1);
            got[15-i] = sdo;
            if (i == 0) chk("R12 low", 32'({sdo, sdo_oe}), 32'h1);
        end
        rb_n = 1'b1;
        wait_clk(6);
        chk("R8", 32'(got), 32'h0F0F);
        chk("R8 code", 32'(code), 32'h0F0F);

        // R9: clear keeps registers
        s0 = sdo;
        clr_n = 1'b0;
        wait_clk(6);
        chk("R9 zero", 32'(zero), 32'h1);
        chk("R9 code", 32'(code), 32'h0F0F);
        chk("R9 sdo", 32'(sdo), 32'(s0));

        // R10: release with strobe high parks
        ld_n = 1'b1;
        wait_clk(4);
        clr_n = 1'b1;
        wait_clk(6);
        chk("R10 parked", 32'(zero), 32'h1);
        ld_n = 1'b0;
        wait_clk(6);
        chk("R10 strobe", 32'(zero), 32'h0);
        clr_n = 1'b0;
        wait_clk(6);
        clr_n = 1'b1;
        wait_clk(6);
        chk("R10 auto", 32'(zero), 32'h0);

        // R11: power-down
        pd = 1'b1;
        wait_clk(6);
        chk("R11 on", 32'(pdn), 32'h1);
        chk("R11 code", 32'(code), 32'h0F0F);
        pd = 1'b0;
        wait_clk(6);
        chk("R11 off", 32'(pdn), 32'h0);
        chk("R11 code after", 32'(code), 32'h0F0F);

        finish_run();
    end
endmodule